// File: doc/BRIEF.md
# BCD Real-Time Clock with Read Freeze

This block keeps calendar time in BCD. The fields are hundredths of a second, seconds, minutes, hours, day of week, day of month, month and year. A single-cycle tick enable advances the count. In a system that tick is a 100 Hz strobe. Software, or a bridge from a serial bus, reaches the block through a byte-wide register port. That port has an address pointer that can be loaded, and every accepted read or write strobe moves the pointer forward by one. A stop bit halts the count. A century bit can flip each time the year wraps, if software has enabled it.

A burst read of the eight time bytes must return one consistent instant. The first read of a time address takes a snapshot of the count. Every later read of a time address returns bytes from that snapshot, while the real counter keeps running underneath. The read of the last time byte moves the pointer past the time area and releases the snapshot. The visible copy then reloads from the live count, so no tick is lost. Writes go straight to the live counter.

Top module: `rtc_bcd_freeze`

## Requirements
- R1: Byte addresses 0..7 hold, in this order: hundredths, seconds, minutes, hours, day of week, day of month, month, year. A read at any address of 8 or higher returns 0x00. A write at any address of 8 or higher changes nothing.
- R2: Each tick adds one hundredth, with BCD carries. The wrap points are: hundredths 99→00, seconds 59→00, minutes 59→00, hours 23→00, day of week 7→1, month 12→01, year 99→00.
- R3: Seconds byte bit 7 is the stop bit. While it is 1, ticks leave the whole count unchanged.
- R4: Hours byte bit 7 enables century toggling and bit 6 is the century bit. The century bit inverts on a year wrap from 99 to 00 only while bit 7 is 1.
- R5: The day of month wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12. It wraps after day 30 in months 04, 06, 09 and 11, and after day 28 in month 02. There are no leap years.
- R6: A read of address 0..7 while no snapshot is held captures the whole count. All later reads of addresses 0..7 return bytes from that capture, while counting continues underneath.
- R7: The read of address 7 releases the capture. After that, reads reflect the live count, including any ticks that arrived during the capture.
- R8: A write to a time address loads that field of the live counter and clears the hundredths to 00. A write to address 0 only clears the hundredths.
- R9: A pointer load sets the pointer, and no access happens in that cycle. Each accepted read or write strobe moves the pointer forward by one. If both strobes are high, the write is taken.
- R10: After reset the eight bytes read 00, 00, 00, 00, 01, 01, 01, 00, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle hundredth-second enable |
| ptr_ld | input | 1 | Load the address pointer from ptr_val |
| ptr_val | input | ADDR_W | New pointer value |
| rd_stb | input | 1 | Read the byte at the pointer, then move the pointer forward |
| wr_stb | input | 1 | Write wdata at the pointer, then move the pointer forward |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid from the cycle after rd_stb |

## Verification
The count is checked with carry patterns of different depths:
- A hundredths-only carry separates BCD nibble carrying from a plain binary increment.
- A full rollover from 23:59:59.99 on a 31 December, year 99, runs every field's wrap in one tick and shows whether the century-enable bit gates the toggle.
- Month-end cases at 28, 30 and 31 days separate the three month lengths from one another.
- A stop-bit run with many ticks shows whether the count truly halts.

The freeze is tested by ticking across a seconds carry between reads of one burst. This separates a coherent snapshot from bytes taken at mixed instants. A re-read afterwards separates catching up on the missed ticks from losing them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int TOD_BYTES = 8;
    localparam int IDX_W     = $clog2(TOD_BYTES);

    typedef struct packed {
        logic [7:0] hsec;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] year;
        logic       stop;
        logic       cen_en;
        logic       century;
    } tod_t;

    function automatic tod_t tod_reset();
        tod_t t;
        t         = '0;
        t.dow     = 8'h01;
        t.day     = 8'h01;
        t.mon     = 8'h01;
        return t;
    endfunction

    // Next BCD value in the range lo..hi, wrapping from hi back to lo.
    function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi);
        if (v == hi)
            return lo;
        else if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon);
        case (mon)
            8'h02:                      return 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] tod_byte(input tod_t t, input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return t.hsec;
            3'd1:    return {t.stop, t.sec[6:0]};
            3'd2:    return t.min;
            3'd3:    return {t.cen_en, t.century, t.hour[5:0]};
            3'd4:    return t.dow;
            3'd5:    return t.day;
            3'd6:    return t.mon;
            default: return t.year;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wdata,
    output tod_t                 cnt
);

    tod_t nxt;
    logic c_hs, c_s, c_m, c_h, c_d, c_mo, c_y;

    always_comb begin
        nxt  = cnt;
        c_hs = tick && !cnt.stop && (cnt.hsec == 8'h99);
        c_s  = c_hs && (cnt.sec  == 8'h59);
        c_m  = c_s  && (cnt.min  == 8'h59);
        c_h  = c_m  && (cnt.hour == 8'h23);
        c_d  = c_h  && (cnt.day  == month_last(cnt.mon));
        c_mo = c_d  && (cnt.mon  == 8'h12);
        c_y  = c_mo && (cnt.year == 8'h99);
        if (tick && !cnt.stop) nxt.hsec = bcd_next(cnt.hsec, 8'h00, 8'h99);
        if (c_hs) nxt.sec  = bcd_next(cnt.sec,  8'h00, 8'h59);
        if (c_s)  nxt.min  = bcd_next(cnt.min,  8'h00, 8'h59);
        if (c_m)  nxt.hour = bcd_next(cnt.hour, 8'h00, 8'h23);
        if (c_h) begin
            nxt.dow = bcd_next(cnt.dow, 8'h01, 8'h07);
            nxt.day = bcd_next(cnt.day, 8'h01, month_last(cnt.mon));
        end
        if (c_d)  nxt.mon  = bcd_next(cnt.mon,  8'h01, 8'h12);
        if (c_mo) nxt.year = bcd_next(cnt.year, 8'h00, 8'h99);
        if (c_y && cnt.cen_en) nxt.century = !cnt.century;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= tod_reset();
        end else if (wr_en) begin
            cnt.hsec <= 8'h00;
            case (wr_idx)
                3'd1: begin
                    cnt.stop <= wdata[7];
                    cnt.sec  <= {1'b0, wdata[6:0]};
                end
                3'd2: cnt.min <= {1'b0, wdata[6:0]};
                3'd3: begin
                    cnt.cen_en  <= wdata[7];
                    cnt.century <= wdata[6];
                    cnt.hour    <= {2'b00, wdata[5:0]};
                end
                3'd4: cnt.dow  <= {5'b0, wdata[2:0]};
                3'd5: cnt.day  <= {2'b0, wdata[5:0]};
                3'd6: cnt.mon  <= {3'b0, wdata[4:0]};
                3'd7: cnt.year <= wdata;
                default: ;
            endcase
        end else begin
            cnt <= nxt;
        end
    end

    p_hsec_bcd_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt.hsec[3:0] <= 4'h9) && (cnt.hsec[7:4] <= 4'h9));

    p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt.stop && !wr_en) |=> $stable(cnt));

    p_century_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (c_y && cnt.cen_en && !wr_en) |=> (cnt.century != $past(cnt.century)));

    p_century_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (!cnt.cen_en && !wr_en) |=> (cnt.century == $past(cnt.century)));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  tod_t              live,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output tod_t              view
);

    localparam logic [ADDR_W-1:0] LAST_TOD = ADDR_W'(TOD_BYTES - 1);

    tod_t vis_q;
    logic frz_q;
    logic in_tod;

    assign in_tod = (rd_addr <= LAST_TOD);
    // While frozen, reads see the held copy; otherwise they see the live count.
    assign view   = frz_q ? vis_q : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_q <= 1'b0;
            vis_q <= tod_reset();
        end else begin
            if (!frz_q) vis_q <= live;
            if (rd_fire && rd_addr == LAST_TOD)
                frz_q <= 1'b0;
            else if (rd_fire && in_tod)
                frz_q <= 1'b1;
        end
    end

    p_hold_while_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        frz_q |=> $stable(vis_q));

    p_catch_up_r7: assert property (@(posedge clk) disable iff (rst)
        !frz_q |=> (vis_q == $past(live)));

    p_release_last_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_addr == LAST_TOD) |=> !frz_q);

endmodule

// File: rtl/rtc_regbus.sv
module rtc_regbus
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  tod_t              view,
    output logic [ADDR_W-1:0] ptr,
    output logic              rd_fire,
    output logic              wr_tod,
    output logic [7:0]        rdata
);

    localparam logic [ADDR_W-1:0] TOD_END = ADDR_W'(TOD_BYTES);

    logic wr_fire;
    logic hit;

    assign wr_fire = !ptr_ld && wr_stb;
    assign rd_fire = !ptr_ld && !wr_stb && rd_stb;
    assign hit     = (ptr < TOD_END);
    assign wr_tod  = wr_fire && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            rdata <= 8'h00;
        end else begin
            if (ptr_ld)
                ptr <= ptr_val;
            else if (wr_fire || rd_fire)
                ptr <= ptr + 1'b1;
            if (rd_fire)
                rdata <= hit ? tod_byte(view, ptr[IDX_W-1:0]) : 8'h00;
        end
    end

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!ptr_ld && (rd_stb || wr_stb)) |=> (ptr == $past(ptr) + 1'b1));

    p_ptr_load_r9: assert property (@(posedge clk) disable iff (rst)
        ptr_ld |=> (ptr == $past(ptr_val)));

    p_oob_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !hit) |=> (rdata == 8'h00));

endmodule

// File: rtl/rtc_bcd_freeze.sv
module rtc_bcd_freeze
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    tod_t              live;
    tod_t              view;
    logic [ADDR_W-1:0] ptr;
    logic              rd_fire;
    logic              wr_tod;

    rtc_tod_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wr_en  (wr_tod),
        .wr_idx (ptr[IDX_W-1:0]),
        .wdata  (wdata),
        .cnt    (live)
    );

    rtc_snapshot #(.ADDR_W(ADDR_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .live    (live),
        .rd_fire (rd_fire),
        .rd_addr (ptr),
        .view    (view)
    );

    rtc_regbus #(.ADDR_W(ADDR_W)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .ptr_ld  (ptr_ld),
        .ptr_val (ptr_val),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .view    (view),
        .ptr     (ptr),
        .rd_fire (rd_fire),
        .wr_tod  (wr_tod),
        .rdata   (rdata)
    );

    p_write_clears_hsec_r8: assert property (@(posedge clk) disable iff (rst)
        wr_tod |=> (live.hsec == 8'h00));

endmodule

// File: tb/tb_rtc_bcd_freeze.sv
module tb_rtc_bcd_freeze;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       ptr_ld = 1'b0;
    logic [7:0] ptr_val = 8'h00;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rb [8];

    always #5 clk = ~clk;

    rtc_bcd_freeze #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .tick(tick), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        @(negedge clk); ptr_ld = 1'b1; ptr_val = a;
        @(negedge clk); ptr_ld = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wdata = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; d = rdata;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic read_all();
        set_ptr(8'h00);
        for (int i = 0; i < 8; i++) rd_byte(rb[i]);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y);
        set_ptr(8'h01);
        wr_byte(s); wr_byte(m); wr_byte(h); wr_byte(w); wr_byte(d); wr_byte(mo); wr_byte(y);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        read_all();
        check("R10 hsec", rb[0], 8'h00); check("R10 sec", rb[1], 8'h00);
        check("R10 min", rb[2], 8'h00);  check("R10 hour", rb[3], 8'h00);
        check("R10 dow", rb[4], 8'h01);  check("R10 day", rb[5], 8'h01);
        check("R10 mon", rb[6], 8'h01);  check("R10 year", rb[7], 8'h00);
        rd_byte(d);
        check("R9 pointer at 8 reads zero (R1)", d, 8'h00);
    endtask

    task automatic t_write_readback();
        do_ticks(7);
        load_time(8'h45, 8'h12, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24);
        read_all();
        check("R8 hsec cleared", rb[0], 8'h00);
        check("R1 sec", rb[1], 8'h45); check("R1 min", rb[2], 8'h12);
        check("R1 hour", rb[3], 8'h08); check("R1 dow", rb[4], 8'h03);
        check("R1 day", rb[5], 8'h15); check("R1 mon", rb[6], 8'h06);
        check("R1 year", rb[7], 8'h24);
        set_ptr(8'h00); wr_byte(8'h77);
        read_all();
        check("R8 addr0 write keeps sec", rb[1], 8'h45);
    endtask

    task automatic t_hsec_carry();
        do_ticks(37);
        read_all();
        check("R2 hsec bcd 37", rb[0], 8'h37);
        do_ticks(63);
        read_all();
        check("R2 hsec wrap", rb[0], 8'h00);
        check("R2 sec carry", rb[1], 8'h46);
    endtask

    task automatic t_full_roll();
        load_time(8'h59, 8'h59, 8'hA3, 8'h07, 8'h31, 8'h12, 8'h99);
        do_ticks(100);
        read_all();
        check("R2 roll sec", rb[1], 8'h00); check("R2 roll min", rb[2], 8'h00);
        check("R4 century set", rb[3], 8'hC0);
        check("R2 dow wrap", rb[4], 8'h01); check("R5 day wrap", rb[5], 8'h01);
        check("R2 mon wrap", rb[6], 8'h01); check("R2 year wrap", rb[7], 8'h00);
        load_time(8'h59, 8'h59, 8'h63, 8'h07, 8'h31, 8'h12, 8'h99);
        do_ticks(100);
        read_all();
        check("R4 no toggle when disabled", rb[3], 8'h40);
        check("R4 year wrapped", rb[7], 8'h00);
    endtask

    task automatic t_month_len();
        load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24);
        do_ticks(100);
        read_all();
        check("R5 30-day month day", rb[5], 8'h01); check("R5 30-day month mon", rb[6], 8'h05);
        check("R2 dow step", rb[4], 8'h03);
        load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24);
        do_ticks(100);
        read_all();
        check("R5 feb day", rb[5], 8'h01); check("R5 feb mon", rb[6], 8'h03);
        load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h24);
        do_ticks(100);
        read_all();
        check("R5 31-day month day", rb[5], 8'h31); check("R5 31-day month mon", rb[6], 8'h01);
    endtask

    task automatic t_stop();
        set_ptr(8'h01); wr_byte(8'h80);
        do_ticks(50);
        read_all();
        check("R3 stopped hsec", rb[0], 8'h00);
        check("R3 stop bit visible", rb[1], 8'h80);
        set_ptr(8'h01); wr_byte(8'h00);
        do_ticks(3);
        read_all();
        check("R3 runs after clear", rb[0], 8'h03);
    endtask

    task automatic t_freeze();
        logic [7:0] d;
        load_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h14, 8'h07, 8'h24);
        do_ticks(99);
        set_ptr(8'h00);
        rd_byte(d); check("R6 first byte", d, 8'h99);
        do_ticks(2);
        rd_byte(d); check("R6 sec frozen across carry", d, 8'h30);
        rd_byte(d); check("R6 min", d, 8'h20);
        do_ticks(1);
        rd_byte(d); check("R6 hour", d, 8'h10);
        rd_byte(d); check("R6 dow", d, 8'h02);
        rd_byte(d); check("R6 day", d, 8'h14);
        rd_byte(d); check("R6 mon", d, 8'h07);
        rd_byte(d); check("R6 year", d, 8'h24);
        read_all();
        check("R7 caught up hsec", rb[0], 8'h02);
        check("R7 caught up sec", rb[1], 8'h31);
    endtask

    task automatic t_out_of_range();
        set_ptr(8'h20); wr_byte(8'h55);
        set_ptr(8'h20);
        begin
            logic [7:0] d;
            rd_byte(d);
            check("R1 high address reads zero", d, 8'h00);
        end
        read_all();
        check("R1 high write ignored", rb[1], 8'h31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_readback();
        t_hsec_carry();
        t_full_roll();
        t_month_len();
        t_stop();
        t_freeze();
        t_out_of_range();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule